// File: doc/BRIEF.md
# Power-Domain Sequencing Controller

This block sits in the always-on part of a chip and controls a gateable accelerator domain. It drives three control lines toward that domain: a power-switch enable, an isolation enable and an active-low domain reset. When software asks for power, the switch is turned on first. The controller then waits a programmable number of settle cycles, releases isolation, and only after that releases the domain reset. When software withdraws the request, the steps run in reverse: reset is asserted, then isolation, and one cycle later the switch opens.

Every signal that leaves the gated domain passes through a clamp inside the block. While isolation is asserted, each crossing bit is forced to its own safe level, taken from a parameter. Otherwise the bit passes straight through.

The request is a level. It is acted on only in the two stable states, so a transition that has started always runs to completion. A two-bit phase code and a ready flag report progress.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After system reset the outputs are as follows: the switch enable is low, isolation is high, the domain reset is asserted (`dom_rst_n` low), the phase is OFF and `ready` is low.
- R2: While the request stays low in the OFF phase, the switch enable stays low and the phase stays OFF.
- R3: A high request seen in OFF raises the switch enable on the next cycle. Isolation falls exactly W cycles after the switch enable rises. W is the `settle_cycles` value sampled on the cycle the controller leaves OFF; a value of 0 selects `DEF_SETTLE` (10000).
- R4: `dom_rst_n` rises exactly one cycle after isolation falls, and it is never high while isolation is high.
- R5: A low request seen in ON drops `dom_rst_n` on the next cycle. Isolation rises one cycle after that, and the switch enable falls one cycle after isolation rises.
- R6: While isolation is high, `aon_in` equals `SAFE_VAL` bit for bit (default 8'hA5). While isolation is low, `aon_in` equals `dom_out`.
- R7: `phase` reads 0 in OFF, 1 while powering up, 2 in ON and 3 while powering down. `ready` is high only in ON.
- R8: A change of the request during a transition neither stops nor reverses that transition. Once the controller reaches ON or OFF, it acts on the request level present at that time.
- R9: Changes to `settle_cycles` after the controller leaves OFF do not alter the current settle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low system reset |
| pwr_req | input | 1 | Software power request level |
| settle_cycles | input | CNT_W | Settle wait in cycles (0 selects default) |
| dom_out | input | N_XING | Signals leaving the gated domain |
| sw_en | output | 1 | Power-switch enable |
| iso_en | output | 1 | Isolation enable |
| dom_rst_n | output | 1 | Active-low domain reset |
| phase | output | 2 | Sequencing phase code |
| ready | output | 1 | Domain powered and out of reset |
| aon_in | output | N_XING | Clamped crossing signals |

## Verification
The hardest situations to reach are a request that reverses while a transition is already running, and a settle value that is rewritten partway through the wait. Both only show up if the stimulus changes inputs at a chosen cycle after the sequence has started. The bench counts cycles from the request edge and flips the request three cycles into a power-up and one cycle into a power-down. In another run it rewrites `settle_cycles` two cycles into the wait. It then measures the spacing between edges on all three control lines. The default settle count is run once in full, so the zero-selects-default path is measured and not assumed.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int N_XING = 8,
  parameter int CNT_W = 16,
  parameter logic [N_XING-1:0] SAFE_VAL = 8'hA5,
  parameter logic [CNT_W-1:0] DEF_SETTLE = 16'd10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_req,
  input  logic [CNT_W-1:0]  settle_cycles,
  input  logic [N_XING-1:0] dom_out,
  output logic              sw_en,
  output logic              iso_en,
  output logic              dom_rst_n,
  output logic [1:0]        phase,
  output logic              ready,
  output logic [N_XING-1:0] aon_in
);

  typedef enum logic [2:0] {
    S_OFF, S_UP_SW, S_UP_ISO, S_ON, S_DN_RST, S_DN_ISO
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      wait_q <= DEF_SETTLE;
    end else begin
      case (st)
        S_OFF: if (pwr_req) begin
          st     <= S_UP_SW;
          cnt    <= '0;
          wait_q <= (settle_cycles == '0) ? DEF_SETTLE : settle_cycles;
        end
        S_UP_SW: begin
          if (cnt == wait_q - 1'b1) st <= S_UP_ISO;
          else cnt <= cnt + 1'b1;
        end
        S_UP_ISO: st <= S_ON;
        S_ON:     if (!pwr_req) st <= S_DN_RST;
        S_DN_RST: st <= S_DN_ISO;
        S_DN_ISO: st <= S_OFF;
        default:  st <= S_OFF;
      endcase
    end
  end

  assign sw_en     = (st != S_OFF);
  assign iso_en    = (st == S_OFF) || (st == S_UP_SW) || (st == S_DN_ISO);
  assign dom_rst_n = (st == S_ON);
  assign ready     = (st == S_ON);

  always_comb begin
    case (st)
      S_OFF:               phase = 2'd0;
      S_UP_SW, S_UP_ISO:   phase = 2'd1;
      S_ON:                phase = 2'd2;
      default:             phase = 2'd3;
    endcase
  end

  for (genvar i = 0; i < N_XING; i++) begin : g_clamp
    assign aon_in[i] = iso_en ? SAFE_VAL[i] : dom_out[i];
  end

endmodule

module pwr_seq_ctrl_chk #(
  parameter int N_XING = 8,
  parameter int CNT_W = 16,
  parameter logic [N_XING-1:0] SAFE_VAL = 8'hA5,
  parameter logic [CNT_W-1:0] DEF_SETTLE = 16'd10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  settle_cycles,
  input logic [N_XING-1:0] dom_out,
  input logic              sw_en,
  input logic              iso_en,
  input logic              dom_rst_n,
  input logic [1:0]        phase,
  input logic              ready,
  input logic [N_XING-1:0] aon_in
);

  logic [CNT_W-1:0] lat;
  logic [CNT_W:0]   held;
  logic [CNT_W-1:0] eff;

  assign eff = (lat == '0) ? DEF_SETTLE : lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= '0;
      held <= '0;
    end else if (phase == 2'd0) begin
      lat  <= settle_cycles;
      held <= '0;
    end else if (sw_en && iso_en) begin
      held <= held + 1'b1;
    end
  end

  p_settle_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> held == {1'b0, eff});

  p_sw_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> iso_en && !dom_rst_n);

  p_rst_after_iso_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rst_n |-> !iso_en);

  p_rst_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst_n) |-> $past(!iso_en) && !$past(dom_rst_n));

  p_sw_off_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> iso_en && $past(iso_en) && !dom_rst_n);

  p_iso_needs_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_en |-> sw_en);

  p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iso_en |-> aon_in == SAFE_VAL);

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_en |-> aon_in == dom_out);

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> phase == 2'd2 && dom_rst_n && sw_en);

  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd0 |-> !sw_en && iso_en && !ready);

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
  .N_XING(N_XING), .CNT_W(CNT_W), .SAFE_VAL(SAFE_VAL), .DEF_SETTLE(DEF_SETTLE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles), .dom_out(dom_out),
  .sw_en(sw_en), .iso_en(iso_en), .dom_rst_n(dom_rst_n), .phase(phase),
  .ready(ready), .aon_in(aon_in)
);

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  localparam int N = 8;
  localparam int CW = 16;
  localparam logic [N-1:0] SAFE = 8'hA5;
  localparam int DEF = 10000;

  logic clk = 0, rst_n = 0, req = 0;
  logic [CW-1:0] settle = '0;
  logic [N-1:0] dom_out = '0;
  logic sw_en, iso_en, dom_rst_n, ready;
  logic [1:0] phase;
  logic [N-1:0] aon_in;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_req(req), .settle_cycles(settle),
    .dom_out(dom_out), .sw_en(sw_en), .iso_en(iso_en), .dom_rst_n(dom_rst_n),
    .phase(phase), .ready(ready), .aon_in(aon_in)
  );

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // one negedge step with fresh crossing data; returns 1 if clamp/R4 rules break
  task automatic step(input int t, output bit bad_clamp, output bit bad_rst);
    @(negedge clk);
    dom_out = N'(t * 37 + 5);
    #1;
    bad_clamp = (aon_in != (iso_en ? SAFE : dom_out));
    bad_rst = dom_rst_n && iso_en;
  endtask

  task automatic t_reset();
    chk(!sw_en, "R1", "sw_en at reset", sw_en, 0);
    chk(iso_en, "R1", "iso_en at reset", iso_en, 1);
    chk(!dom_rst_n, "R1", "dom_rst_n at reset", dom_rst_n, 0);
    chk(phase == 0 && !ready, "R1", "phase at reset", phase, 0);
  endtask

  task automatic t_idle();
    bit bc, br, any_on = 0, any_bc = 0;
    for (int t = 1; t <= 20; t++) begin
      step(t, bc, br);
      if (sw_en || phase != 0) any_on = 1;
      if (bc) any_bc = 1;
    end
    chk(!any_on, "R2", "stays off without request", any_on, 0);
    chk(!any_bc, "R6", "clamp while idle", any_bc, 0);
  endtask

  task automatic t_up(int w, bit chg);
    int weff = (w == 0) ? DEF : w;
    int n_sw = -1, n_iso = -1, n_rst = -1;
    bit bc, br, any_bc = 0, any_br = 0, bad_ph = 0;
    @(negedge clk);
    settle = CW'(w);
    req = 1;
    for (int t = 1; t <= weff + 20 && n_rst < 0; t++) begin
      step(t, bc, br);
      if (chg && t == 2) settle = CW'(3 * weff + 1);
      if (bc) any_bc = 1;
      if (br) any_br = 1;
      if (n_sw < 0 && sw_en) n_sw = t;
      if (n_iso < 0 && !iso_en) n_iso = t;
      if (n_rst < 0 && dom_rst_n) n_rst = t;
      if (n_rst < 0 && (phase != 1 || ready)) bad_ph = 1;
    end
    chk(n_sw == 1, "R3", "switch rises next cycle", n_sw, 1);
    chk(n_iso - n_sw == weff, chg ? "R9" : "R3", "settle length", n_iso - n_sw, weff);
    chk(n_rst - n_iso == 1, "R4", "reset after isolation", n_rst - n_iso, 1);
    chk(!any_br, "R4", "reset high under isolation", any_br, 0);
    chk(!any_bc, "R6", "clamp/pass during power-up", any_bc, 0);
    chk(!bad_ph, "R7", "phase 1 while powering up", bad_ph, 0);
    chk(phase == 2 && ready, "R7", "phase ON with ready", phase, 2);
  endtask

  task automatic t_down();
    int n_r = -1, n_i = -1, n_s = -1;
    bit bc, br, any_bc = 0, bad_ph = 0;
    @(negedge clk);
    req = 0;
    for (int t = 1; t <= 10 && n_s < 0; t++) begin
      step(t, bc, br);
      if (bc) any_bc = 1;
      if (n_r < 0 && !dom_rst_n) n_r = t;
      if (n_i < 0 && iso_en) n_i = t;
      if (n_s < 0 && !sw_en) n_s = t;
      if (n_s < 0 && (phase != 3 || ready)) bad_ph = 1;
    end
    chk(n_r == 1, "R5", "reset drops first", n_r, 1);
    chk(n_i == 2, "R5", "isolation second", n_i, 2);
    chk(n_s == 3, "R5", "switch off third", n_s, 3);
    chk(!any_bc, "R6", "clamp during power-down", any_bc, 0);
    chk(!bad_ph, "R7", "phase 3 while powering down", bad_ph, 0);
    chk(phase == 0, "R7", "phase OFF after down", phase, 0);
  endtask

  task automatic t_flip_up();
    bit bc, br, seen_on = 0;
    int t_on = -1;
    @(negedge clk);
    settle = 8;
    req = 1;
    for (int t = 1; t <= 40 && t_on < 0; t++) begin
      step(t, bc, br);
      if (t == 3) req = 0;
      if (phase == 2) begin seen_on = 1; t_on = t; end
    end
    chk(seen_on && t_on == 10, "R8", "up completes despite drop", t_on, 10);
    step(0, bc, br);
    chk(phase == 3, "R8", "then powers down", phase, 3);
    for (int t = 0; t < 5; t++) step(t, bc, br);
    chk(phase == 0 && !sw_en, "R8", "back to OFF", phase, 0);
  endtask

  task automatic t_flip_down();
    bit bc, br;
    int n_s = -1, n_back = -1;
    @(negedge clk);
    req = 0;
    for (int t = 1; t <= 12 && n_back < 0; t++) begin
      step(t, bc, br);
      if (t == 1) req = 1;
      if (n_s < 0 && !sw_en) n_s = t;
      if (n_s > 0 && n_back < 0 && sw_en) n_back = t;
    end
    chk(n_s == 3, "R8", "down completes despite raise", n_s, 3);
    chk(n_back == 4, "R8", "re-powers from OFF", n_back, 4);
    for (int t = 0; t < 20 && phase != 2; t++) step(t, bc, br);
    chk(phase == 2, "R8", "reaches ON again", phase, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_idle();
    t_up(5, 0);
    t_down();
    t_up(1, 0);
    t_down();
    t_up(4, 1);
    t_down();
    t_flip_up();
    t_up(6, 0);
    t_flip_down();
    t_down();
    t_up(0, 0);
    t_down();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule